// File: doc/BRIEF.md
# Video RAM Transfer-Cycle Wait Generator

This block holds a processor in wait states while a video RAM shift-register load (transfer) cycle runs on one processor port. An early request input announces that a transfer is coming. The transfer itself begins when a transfer strobe is sampled high on a rising clock edge. While the transfer lasts, the block drives an active-low transfer/output-enable strobe to the memory, raises WAIT and keeps the active-low acknowledge negated.

A transfer ends at the first of two events. One is the strobe being sampled low. The other is a fixed number of clocks passing since the start, four by default. A mode bit chooses how WAIT ends. It can drop on the rising edge that ends the transfer, or one half clock later on the next falling edge. After a transfer that ended by timeout, the acknowledge is asserted from the moment WAIT drops until the strobe is removed. A strobe that is still held after a timeout cannot start a second transfer.

Top module: `vxw_wait_gen`

## Requirements
- R1: While reset is asserted, and on the first cycles after it, dt_oe_n_o is 1, wait_o is 0 and dtack_n_o is 1. Asserting rst_n low forces these values at once, without waiting for a clock.
- R2: When the block is armed and idle, a rising edge that samples xfer_stb_i high starts a transfer. dt_oe_n_o goes to 0 and wait_o goes to 1 right after that edge, in both release modes.
- R3: wait_o is always the inverse of dt_oe_n_o.
- R4: The first rising edge during a transfer that samples xfer_stb_i low ends the transfer.
- R5: If xfer_stb_i stays high, the transfer ends on the XFER_CLKS-th rising edge after the start edge. With the default of 4, wait_o is high for 4 clock periods.
- R6: With half_rel_i = 0, wait_o drops on the same rising edge that ends the transfer.
- R7: With half_rel_i = 1, wait_o drops on the falling edge that follows the ending rising edge, half a clock later. The start of the transfer is not delayed.
- R8: After a transfer ends by timeout, dtack_n_o goes to 0 at the same moment wait_o drops. It returns to 1 as soon as xfer_stb_i goes low. At all other times it stays 1, including after a transfer ended by strobe release, and it is never 0 while wait_o is 1.
- R9: After a timeout, a strobe that stays high does not start a new transfer. The block re-arms only after a rising edge samples xfer_stb_i low.
- R10: Pulses on xfer_req_i while xfer_stb_i is low leave all three outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock. Both edges are used. |
| rst_n | input | 1 | Asynchronous active-low reset. It is released synchronously inside the block. |
| xfer_req_i | input | 1 | Early notice that a transfer is about to happen. |
| xfer_stb_i | input | 1 | Transfer strobe, active high. It marks the start and the span of the transfer. |
| half_rel_i | input | 1 | Release mode: 0 releases WAIT on the rising edge, 1 releases it half a clock later. |
| dt_oe_n_o | output | 1 | Transfer/output-enable strobe to the video RAM, active low. |
| wait_o | output | 1 | Wait request to the processor, active high. |
| dtack_n_o | output | 1 | Data acknowledge to the processor, active low. |

## Verification
The embedded properties make two assumptions about the inputs. First, every rising edge of the transfer strobe comes after a request has been seen since the previous transfer. Second, the release-mode bit does not change while a transfer is running. The directed scenarios respect both. Each strobe is preceded by a one-cycle request pulse, the mode bit is changed only while the block is idle, and the strobe is held low whenever reset is asserted. Within those limits the scenarios cover both release modes with both ending causes, a strobe held past timeout, a re-arm after release, request-only traffic and a reset asserted in the middle of a transfer.

// File: rtl/vxw_pkg.sv
package vxw_pkg;

  // Default length of a transfer, in clocks, when the strobe is held.
  parameter int unsigned DEF_XFER_CLKS = 4;

  // When WAIT is released at the end of a transfer.
  typedef enum logic {
    REL_RISE = 1'b0,  // on the ending rising edge
    REL_HALF = 1'b1   // on the falling edge that follows it
  } rel_mode_e;

endpackage

// File: rtl/vxw_strobe_track.sv
module vxw_strobe_track (
  input  logic clk,
  input  logic rst_sn,
  input  logic stb_i,
  input  logic req_i,
  input  logic active_i,
  input  logic timeout_end_i,
  output logic start_o,
  output logic served_o
);

  logic armed_q, armed_d;
  logic served_q, served_d;
  logic req_seen_q, req_seen_d;

  // A transfer may start only when armed and no transfer is running.
  assign start_o  = stb_i & armed_q & ~active_i;
  assign served_o = served_q;

  always_comb begin
    armed_d    = armed_q;
    served_d   = served_q;
    req_seen_d = req_seen_q;
    if (!stb_i) begin
      armed_d  = 1'b1;
      served_d = 1'b0;
    end else begin
      if (start_o)       armed_d  = 1'b0;
      if (timeout_end_i) served_d = 1'b1;
    end
    if (start_o)    req_seen_d = 1'b0;
    else if (req_i) req_seen_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      armed_q    <= 1'b0;
      served_q   <= 1'b0;
      req_seen_q <= 1'b0;
    end else begin
      armed_q    <= armed_d;
      served_q   <= served_d;
      req_seen_q <= req_seen_d;
    end
  end

  // R9: once disarmed and idle, the next edge cannot leave a transfer running.
  assert_no_retrigger_R9: assert property (@(posedge clk) disable iff (!rst_sn)
    (!armed_q && !active_i) |=> !active_i);

  // R10 (input assumption): a strobe rise is always announced by a request.
  assert_req_before_stb_R10: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(stb_i) |-> req_seen_q);

endmodule

// File: rtl/vxw_xfer_timer.sv
module vxw_xfer_timer #(
  parameter int unsigned XFER_CLKS = vxw_pkg::DEF_XFER_CLKS,
  localparam int unsigned CNT_W = $clog2(XFER_CLKS + 1)
) (
  input  logic clk,
  input  logic rst_sn,
  input  logic start_i,
  input  logic stb_i,
  output logic active_o,
  output logic timeout_end_o
);

  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(XFER_CLKS);
  localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(1);

  logic             active_q, active_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             upd_en;

  assign active_o      = active_q;
  assign timeout_end_o = active_q & stb_i & (cnt_q == LAST_VAL);
  assign upd_en        = start_i | active_q;

  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    if (active_q) begin
      if (!stb_i || cnt_q == LAST_VAL) begin
        active_d = 1'b0;
        cnt_d    = '0;
      end else begin
        cnt_d = cnt_q - LAST_VAL;
      end
    end else if (start_i) begin
      active_d = 1'b1;
      cnt_d    = LOAD_VAL;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (upd_en) begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
    end
  end

  // R4: a strobe sampled low during a transfer ends it on that edge.
  assert_end_on_release_R4: assert property (@(posedge clk) disable iff (!rst_sn)
    (active_q && !stb_i) |=> !active_q);

  // R5: the final count ends the transfer.
  assert_timeout_end_R5: assert property (@(posedge clk) disable iff (!rst_sn)
    (active_q && cnt_q == LAST_VAL) |=> !active_q);

  // R2: an accepted start leaves the transfer running after the edge.
  assert_start_runs_R2: assert property (@(posedge clk) disable iff (!rst_sn)
    start_i |=> active_q);

endmodule

// File: rtl/vxw_release_stage.sv
module vxw_release_stage (
  input  logic clk,
  input  logic rst_sn,
  input  logic half_i,
  input  logic active_i,
  output logic xfer_on_o
);
  import vxw_pkg::*;

  rel_mode_e mode;
  logic      tail_q;

  assign mode = rel_mode_e'(half_i);

  // Captures the transfer state on the falling edge, so it can hold
  // WAIT for half a clock after the transfer flag clears.
  always_ff @(negedge clk or negedge rst_sn) begin
    if (!rst_sn) tail_q <= 1'b0;
    else         tail_q <= active_i;
  end

  assign xfer_on_o = active_i | ((mode == REL_HALF) & tail_q);

  // R7 (input assumption): the release mode is held steady during a transfer.
  assert_mode_stable_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    active_i |-> $stable(half_i));

endmodule

// File: rtl/vxw_wait_gen.sv
module vxw_wait_gen #(
  parameter int unsigned XFER_CLKS = vxw_pkg::DEF_XFER_CLKS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic xfer_req_i,
  input  logic xfer_stb_i,
  input  logic half_rel_i,
  output logic dt_oe_n_o,
  output logic wait_o,
  output logic dtack_n_o
);

  logic [1:0] rst_pipe_q;
  logic       rst_sn;
  logic       start, active, timeout_end, served, xfer_on;

  // Reset asserts at once and releases on a rising edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sn = rst_pipe_q[1];

  vxw_strobe_track u_track (
    .clk           (clk),
    .rst_sn        (rst_sn),
    .stb_i         (xfer_stb_i),
    .req_i         (xfer_req_i),
    .active_i      (active),
    .timeout_end_i (timeout_end),
    .start_o       (start),
    .served_o      (served)
  );

  vxw_xfer_timer #(.XFER_CLKS(XFER_CLKS)) u_timer (
    .clk           (clk),
    .rst_sn        (rst_sn),
    .start_i       (start),
    .stb_i         (xfer_stb_i),
    .active_o      (active),
    .timeout_end_o (timeout_end)
  );

  vxw_release_stage u_rel (
    .clk       (clk),
    .rst_sn    (rst_sn),
    .half_i    (half_rel_i),
    .active_i  (active),
    .xfer_on_o (xfer_on)
  );

  assign dt_oe_n_o = ~xfer_on;
  assign wait_o    = xfer_on;
  assign dtack_n_o = ~(served & xfer_stb_i & ~xfer_on);

  // R8: acknowledge and wait are never active together.
  assert_ack_excl_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    !(wait_o && !dtack_n_o));

  // R8: the acknowledge is only given while the strobe is still present.
  assert_ack_needs_stb_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    !dtack_n_o |-> xfer_stb_i);

endmodule

// File: tb/tb_vxw_wait_gen.sv
`timescale 1ns/1ps
module tb_vxw_wait_gen;

  logic clk = 1'b0;
  logic rst_n, req, stb, half;
  logic dt_oe_n, wait_s, dtack_n;
  int   tests_run = 0;
  int   tests_failed = 0;

  always #2.5 clk = ~clk;

  vxw_wait_gen dut (
    .clk(clk), .rst_n(rst_n), .xfer_req_i(req), .xfer_stb_i(stb),
    .half_rel_i(half), .dt_oe_n_o(dt_oe_n), .wait_o(wait_s), .dtack_n_o(dtack_n)
  );

  // Outputs packed as {dt_oe_n, wait, dtack_n}.
  localparam logic [2:0] IDLE = 3'b101;
  localparam logic [2:0] BUSY = 3'b011;
  localparam logic [2:0] ACK  = 3'b100;

  task automatic chk(input string tag, input logic [2:0] exp);
    logic [2:0] act;
    act = {dt_oe_n, wait_s, dtack_n};
    tests_run++;
    if (act !== exp) begin
      tests_failed++;
      $display("FAIL %s: outputs {oe_n,wait,ack_n} = %b, expected %b at %0t", tag, act, exp, $time);
    end
    if (wait_s !== ~dt_oe_n) begin
      tests_failed++;
      $display("FAIL R3: wait=%b oe_n=%b, expected inverse at %0t", wait_s, dt_oe_n, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic announce();
    req = 1'b1; tick(); req = 1'b0; tick();
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req = 1'b0; stb = 1'b0; half = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
  endtask

  task automatic t_reset_state();
    chk("R1 after reset", IDLE);
    tick();
    chk("R1 idle", IDLE);
  endtask

  task automatic t_timeout(input logic h);
    half = h; tick();
    announce();
    stb = 1'b1;
    tick(); chk("R2 start", BUSY);
    for (int i = 0; i < 3; i++) begin tick(); chk("R5 held busy", BUSY); end
    tick();
    if (!h) chk("R6 release on rising edge", ACK);
    else begin
      chk("R7 still waiting after rising edge", BUSY);
      @(negedge clk); #1;
      chk("R7 release on falling edge", ACK);
      @(posedge clk); #1;
    end
    for (int i = 0; i < 3; i++) begin tick(); chk("R9 no retrigger", ACK); end
    stb = 1'b0; #1;
    chk("R8 ack drops with strobe", IDLE);
    tick(); chk("R8 idle after strobe", IDLE);
  endtask

  task automatic t_early_end(input logic h);
    half = h; tick();
    announce();
    stb = 1'b1;
    tick(); chk("R2 start", BUSY);
    tick(); chk("R4 still busy", BUSY);
    stb = 1'b0;
    tick();
    if (!h) chk("R4 ended by release", IDLE);
    else begin
      chk("R7 tail after release", BUSY);
      @(negedge clk); #1;
      chk("R8 no ack after release end", IDLE);
      @(posedge clk); #1;
    end
    tick(); chk("R4 idle", IDLE);
  endtask

  task automatic t_req_only();
    for (int i = 0; i < 4; i++) begin
      req = 1'b1; tick(); chk("R10 request only", IDLE);
      req = 1'b0; tick(); chk("R10 request only", IDLE);
    end
  endtask

  task automatic t_reset_mid();
    half = 1'b1; tick();
    announce();
    stb = 1'b1;
    tick(); chk("R2 start before reset", BUSY);
    rst_n = 1'b0; stb = 1'b0; #1;
    chk("R1 async reset mid transfer", IDLE);
    tick(); rst_n = 1'b1;
    tick(); chk("R1 during release", IDLE);
    repeat (3) tick();
  endtask

  initial begin
    #1_000_000;
    tests_failed++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    #1;
    do_reset();
    t_reset_state();
    t_timeout(1'b0);
    t_timeout(1'b1);
    t_early_end(1'b0);
    t_early_end(1'b1);
    t_req_only();
    t_timeout(1'b0);
    t_reset_mid();
    t_early_end(1'b0);
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

endmodule